// File: doc/BRIEF.md
# Three-Lane Word Serializer with Forwarded Clock

This block turns a 21-bit parallel word into three serial lanes of seven bits each, plus a fourth lane that carries a framing clock so a receiver can recover word boundaries. All logic runs in one fast clock domain. A one-cycle strobe marks each bit period. Every seventh strobe is a word boundary: the parallel input is captured there and is fully transmitted over the next seven bit periods.

An active-low power-down input releases all four lanes. The lanes are modelled as driven values with output enables, and power-down drops every enable. When power-down is released, the enables stay low until a complete fresh word has been loaded. The receiver therefore never sees a partial word or a broken clock pattern.

Top module: `tri_lane_serializer`

## Requirements
- R1: During reset and after its release, every output enable and every lane value is 0. The first bit strobe after reset (with power-down high) is a word boundary.
- R2: `word_in` is sampled only at a word boundary, which is a strobed clock edge in slot 6. Changes on `word_in` at any other time do not affect the lanes.
- R3: Lane k carries word bits 7k to 7k+6. Bit 7k+s goes out in slot s, so slot 0 holds the least significant bit of the lane.
- R4: The slot advances by one only on a clock edge where `bit_en` is high. While `bit_en` is low, every lane value holds.
- R5: In each word period the clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6. Its rising edge comes two bit periods before slot 0, and slot 0 starts every word.
- R6: When `pwr_dn_n` is low at a clock edge, all four output enables are 0 after that edge, all lane values are 0, and the partly sent word is discarded.
- R7: After `pwr_dn_n` returns high, the enables stay 0 until the next word boundary. They then turn 1 with slot 0 of the newly captured word on the lanes.
- R8: The three data-lane enables and the clock-lane enable are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per bit period (7 per word period) |
| pwr_dn_n | input | 1 | Active-low power-down |
| word_in | input | 21 | Parallel word, sampled at the word boundary |
| lane_out | output | 3 | Serial data lanes, one bit per lane |
| lane_oe | output | 3 | Per-lane output enable (0 = high impedance) |
| fclk_out | output | 1 | Forwarded framing clock lane |
| fclk_oe | output | 1 | Clock-lane output enable |

## Verification
The assertions assume that `bit_en` and `pwr_dn_n` are clean synchronous levels sampled at the clock edge. They make no assumption about how often `bit_en` pulses, so the stimulus uses both a continuous strobe and an irregular, gappy strobe. Power-down is asserted in the middle of a word and released at arbitrary slots. `word_in` is changed on every cycle in some phases, so that only the sample taken at the word boundary can match the reference model.

// File: rtl/tls_pkg.sv
package tls_pkg;
    localparam int LANES_DEF = 3;
    localparam int SLOTS_DEF = 7;

    // Framing pattern, bit s = slot s: high for the two first and two last slots.
    function automatic logic [SLOTS_DEF-1:0] fwd_pattern();
        logic [SLOTS_DEF-1:0] p;
        for (int s = 0; s < SLOTS_DEF; s++)
            p[s] = (s < 2) || (s >= SLOTS_DEF - 2);
        return p;
    endfunction
endpackage

// File: rtl/tls_slot_ctr.sv
module tls_slot_ctr #(
    parameter int SLOTS = 7,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic pwr_dn_n,
    output logic load
);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    logic [SW-1:0] slot_q;

    // A word boundary is a strobed edge while in the last slot.
    assign load = bit_en && pwr_dn_n && (slot_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !pwr_dn_n)
            slot_q <= LAST;
        else if (bit_en)
            slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
endmodule

// File: rtl/tls_shifter.sv
module tls_shifter #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             bit_en,
    input  logic             load,
    input  logic [SLOTS-1:0] din,
    output logic             sbit
);
    logic [SLOTS-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst || flush)
            sh_q <= '0;
        else if (load)
            sh_q <= din;
        else if (bit_en)
            sh_q <= {1'b0, sh_q[SLOTS-1:1]};
    end

    assign sbit = sh_q[0];
endmodule

// File: rtl/tri_lane_serializer.sv
module tri_lane_serializer
    import tls_pkg::*;
#(
    parameter int LANES = LANES_DEF,
    parameter int SLOTS = SLOTS_DEF,
    localparam int WORD_W = LANES * SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              pwr_dn_n,
    input  logic [WORD_W-1:0] word_in,
    output logic [LANES-1:0]  lane_out,
    output logic [LANES-1:0]  lane_oe,
    output logic              fclk_out,
    output logic              fclk_oe
);
    logic             load;
    logic             oe_q;
    logic [LANES-1:0] lane_bit;
    logic             fclk_bit;

    tls_slot_ctr #(.SLOTS(SLOTS)) slot_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .pwr_dn_n(pwr_dn_n), .load(load)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tls_shifter #(.SLOTS(SLOTS)) sh_i (
            .clk(clk), .rst(rst), .flush(!pwr_dn_n), .bit_en(bit_en),
            .load(load), .din(word_in[k*SLOTS +: SLOTS]), .sbit(lane_bit[k])
        );
    end

    tls_shifter #(.SLOTS(SLOTS)) fclk_sh_i (
        .clk(clk), .rst(rst), .flush(!pwr_dn_n), .bit_en(bit_en),
        .load(load), .din(fwd_pattern()), .sbit(fclk_bit)
    );

    // Enables rise only with a freshly loaded word; fall on power-down.
    always_ff @(posedge clk) begin
        if (rst || !pwr_dn_n)
            oe_q <= 1'b0;
        else if (load)
            oe_q <= 1'b1;
    end

    assign lane_out = lane_bit & {LANES{oe_q}};
    assign lane_oe  = {LANES{oe_q}};
    assign fclk_out = fclk_bit & oe_q;
    assign fclk_oe  = oe_q;
endmodule

// File: rtl/tls_checker.sv
module tls_checker #(
    parameter int LANES = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_en,
    input logic             pwr_dn_n,
    input logic [LANES-1:0] lane_out,
    input logic [LANES-1:0] lane_oe,
    input logic             fclk_out,
    input logic             fclk_oe
);
    // R6: power-down drops every enable at the next edge
    a_r6_pd_disables: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_n |=> (!fclk_oe && lane_oe == '0));

    // R8: all enables agree
    a_r8_oe_agree: assert property (@(posedge clk) disable iff (rst)
        lane_oe == {LANES{fclk_oe}});

    // R7: enables turn on only after a strobed edge with power-down released
    a_r7_enable_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(fclk_oe) |-> ($past(bit_en) && $past(pwr_dn_n)));

    // R5: the first slot shown after enabling is a high clock slot
    a_r5_start_high: assert property (@(posedge clk) disable iff (rst)
        $rose(fclk_oe) |-> fclk_out);

    // R4: without a strobe the lanes hold
    a_r4_hold_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (fclk_oe && $past(fclk_oe) && !$past(bit_en)) |->
            ($stable(lane_out) && $stable(fclk_out)));
endmodule

bind tri_lane_serializer tls_checker #(.LANES(LANES)) chk_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pwr_dn_n(pwr_dn_n),
    .lane_out(lane_out), .lane_oe(lane_oe), .fclk_out(fclk_out), .fclk_oe(fclk_oe)
);

// File: tb/tri_lane_serializer_tb_top.sv
module tri_lane_serializer_tb_top;
    localparam int NL = 3;
    localparam int NS = 7;
    localparam int NW = NL * NS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bit_en = 1'b0;
    logic          pwr_dn_n = 1'b1;
    logic [NW-1:0] word_in = '0;
    logic [NL-1:0] lane_out;
    logic [NL-1:0] lane_oe;
    logic          fclk_out;
    logic          fclk_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    string tag = "R1";

    // behavioural reference state
    int            m_slot = NS - 1;
    logic [NW-1:0] m_word = '0;
    bit            m_oe   = 1'b0;

    always #10 clk = ~clk;

    tri_lane_serializer dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .pwr_dn_n(pwr_dn_n),
        .word_in(word_in), .lane_out(lane_out), .lane_oe(lane_oe),
        .fclk_out(fclk_out), .fclk_oe(fclk_oe)
    );

    function automatic bit clk_slot(int s);
        return (s == 0 || s == 1 || s == 5 || s == 6);
    endfunction

    task automatic compare();
        logic [NL-1:0] e_lane;
        logic          e_fclk;
        for (int k = 0; k < NL; k++)
            e_lane[k] = m_oe ? m_word[k*NS + m_slot] : 1'b0;
        e_fclk = m_oe ? clk_slot(m_slot) : 1'b0;
        n_tests++;
        if (lane_out !== e_lane) begin
            n_fail++;
            $display("FAIL R3 (%s) lane_out=%b expected %b", tag, lane_out, e_lane);
        end
        n_tests++;
        if (fclk_out !== e_fclk) begin
            n_fail++;
            $display("FAIL R5 (%s) fclk_out=%b expected %b", tag, fclk_out, e_fclk);
        end
        n_tests++;
        if (fclk_oe !== m_oe || lane_oe !== {NL{m_oe}}) begin
            n_fail++;
            $display("FAIL R8 (%s) oe=%b/%b expected %b", tag, lane_oe, fclk_oe, m_oe);
        end
    endtask

    // One clock: check outputs, apply new inputs, advance the model.
    task automatic step(input bit r, input bit be, input bit pdn, input logic [NW-1:0] w);
        @(negedge clk);
        compare();
        rst = r; bit_en = be; pwr_dn_n = pdn; word_in = w;
        if (r) begin
            m_slot = NS - 1; m_oe = 1'b0; m_word = '0;
        end else if (!pdn) begin
            m_slot = NS - 1; m_oe = 1'b0;
        end else if (be) begin
            if (m_slot == NS - 1) begin
                m_slot = 0; m_word = w; m_oe = 1'b1;
            end else begin
                m_slot++;
            end
        end
    endtask

    function automatic logic [NW-1:0] rnd_word();
        return NW'({$urandom, $urandom});
    endfunction

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (4) step(1, 1, 1, rnd_word());
        @(negedge clk);
        n_tests++;
        if (lane_oe !== '0 || fclk_oe !== 1'b0 || lane_out !== '0 || fclk_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 oe=%b/%b out=%b/%b expected all 0", lane_oe, fclk_oe, lane_out, fclk_out);
        end
        step(0, 0, 1, '0);
        step(0, 0, 1, '0);
        // first strobe after reset loads a word (R1, R3)
        tag = "R3";
        step(0, 1, 1, 21'h1FFFFF);
        for (int i = 0; i < 7; i++) step(0, 1, 1, '0);
        for (int i = 0; i < 7; i++) step(0, 1, 1, 21'h0AAAAA);
        for (int i = 0; i < 7; i++) step(0, 1, 1, 21'h155555);
        for (int b = 0; b < NW; b++)
            for (int i = 0; i < 7; i++) step(0, 1, 1, NW'(1) << b);
        // R2: word_in churns every cycle; only the boundary sample counts
        tag = "R2";
        for (int i = 0; i < 140; i++) step(0, 1, 1, rnd_word());
        // R4: irregular strobe
        tag = "R4";
        for (int i = 0; i < 300; i++) step(0, ($urandom % 3) != 0, 1, rnd_word());
        // R6: power-down mid-word
        tag = "R6";
        for (int i = 0; i < 3; i++) step(0, 1, 1, rnd_word());
        for (int i = 0; i < 5; i++) step(0, 1, 0, rnd_word());
        // R7: release, enables wait for the boundary
        tag = "R7";
        step(0, 0, 1, rnd_word());
        step(0, 0, 1, rnd_word());
        step(0, 1, 1, 21'h123456);
        for (int i = 0; i < 20; i++) step(0, 1, 1, rnd_word());
        for (int rep = 0; rep < 6; rep++) begin
            tag = "R6";
            for (int i = 0; i < int'($urandom % 9); i++) step(0, ($urandom % 2) == 0, 1, rnd_word());
            for (int i = 0; i < 1 + int'($urandom % 4); i++) step(0, ($urandom % 2) == 0, 0, rnd_word());
            tag = "R7";
            for (int i = 0; i < 30; i++) step(0, ($urandom % 4) != 0, 1, rnd_word());
        end
        tag = "R8";
        for (int i = 0; i < 20; i++) step(0, 1, 1, rnd_word());
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R4 watchdog: run not finished, expected end before 200000 cycles");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule